// File: doc/BRIEF.md
# Slave Stereo Serial Audio Transmitter

This block sends stereo PCM samples out on one serial data line. It does not make its own audio clocks. An external master supplies a bit clock and a frame clock, and the block follows both. It samples them with its own system clock `clk`, which must run at least eight times faster than the bit clock. A frame clock period holds two channel halves. The left word goes out while the frame clock is high and the right word goes out while it is low. Each word leaves MSB first and starts one bit clock after the frame clock edge that opens its half.

Software or an upstream datapath presents a 24-bit left/right pair and pulses a load strobe. The pair waits in a holding stage and moves into the transmit stage only when a left half begins, so a frame never carries words from two different pairs. The block needs no configuration for 32 or 24 bit-clock slots per channel. Each word is shifted out on its own and the frame clock edges mark the halves. If the frame clock stops toggling, the block halts, holds the line low, and waits for a clean left-half start.

The controller has four states:
- `ST_SYNC`: entered at reset. It waits for a rising frame clock edge.
- `ST_LEFT`: the left half is in progress.
- `ST_RIGHT`: the right half is in progress.
- `ST_HALT`: the frame clock has stopped.

It has these transitions:
- SYNC→LEFT on a rising frame edge.
- LEFT→RIGHT on a falling frame edge.
- RIGHT→LEFT on a rising frame edge.
- LEFT→HALT and RIGHT→HALT on a stall timeout.
- HALT→LEFT on a rising frame edge.

Top module: `aud_ser_tx`

## Requirements
- R1: After reset, and until the frame clock has been seen low and then rising at a bit clock rising edge, the data line stays low. A frame clock that is already high when reset ends does not start output.
- R2: A slot is one bit clock period that begins at a falling bit clock edge. Slot 0 of a half is the slot in which the frame clock changes. The left word is sent MSB first in slots 1 to 24 of the half where the frame clock is high. The right word is sent the same way in the half where it is low.
- R3: The data line changes only after a falling bit clock edge, so it is stable at every rising edge where a receiver captures it.
- R4: With 32 slots per channel, slots 25 to 31 of each half and slot 0 of the following half carry zeros.
- R5: With 24 slots per channel, a word's LSB goes out in slot 0 of the following half.
- R6: A pulse on the load strobe stores the pair. The pair is sent starting with the next left half. A load during a frame does not change any bit of that frame.
- R7: When no new pair is loaded, each frame repeats the last pair that was transferred.
- R8: After 40 bit clock rising edges (parameter `HALT_SLOTS`) with no frame clock change, the block halts. From the next falling bit clock edge the line is low. A falling frame clock edge does not resume output; only a rising one starts a new left half.
- R9: The slot count per channel may change from one frame to the next with no configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Bit clock from the master |
| frame_i | input | 1 | Frame clock from the master; high = left half |
| load_i | input | 1 | One-cycle strobe that stores `left_i`/`right_i` |
| left_i | input | WORD_W (24) | Left channel sample |
| right_i | input | WORD_W (24) | Right channel sample |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The hardest conditions to reach from the ports are the halt and the recovery from it. The frame clock must be held for more than forty slots while the bit clock keeps running. It must then restart with a falling edge, which the block has to ignore. The stimulus holds the frame clock high for fifty slots and then drives a complete low half. Every bit of that half must read zero, where a block that did not halt would send the right word. A full frame afterwards shows that output resumes only at the left half. A second hard case is a reset that ends while the frame clock is already high. The bench asserts reset in the middle of a left half and leaves the frame clock high. It then confirms that no bit appears until a genuine low-to-high transition.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    // Controller states of the serial transmitter
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2,
        ST_HALT  = 2'd3
    } state_e;

endpackage

// File: rtl/aud_ser_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
// STAGES must be at least 2.
module aud_ser_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d_i[g]};
            end
        end

        assign q_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/aud_ser_pair_hold.sv
// Two-stage sample storage: holding registers written by the load strobe,
// transmit registers refreshed only when a left half begins.
module aud_ser_pair_hold #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    input  logic              xfer_i,
    output logic [WORD_W-1:0] frame_l_o,
    output logic [WORD_W-1:0] frame_r_o
);

    logic [WORD_W-1:0] hold_l;
    logic [WORD_W-1:0] hold_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (load_i) begin
            hold_l <= left_i;
            hold_r <= right_i;
        end
    end

    // A transfer in the same cycle as a load takes the older pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_l_o <= '0;
            frame_r_o <= '0;
        end else if (xfer_i) begin
            frame_l_o <= hold_l;
            frame_r_o <= hold_r;
        end
    end

endmodule

// File: rtl/aud_ser_shifter.sv
// Output shift register. Every update happens on a detected falling bit clock
// edge: a word is loaded at the first falling edge of its half, then zeros are
// shifted in behind it.
module aud_ser_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              active_i,
    input  logic              start_i,
    input  logic              sel_right_i,
    input  logic [WORD_W-1:0] left_w_i,
    input  logic [WORD_W-1:0] right_w_i,
    output logic              sdata_o
);

    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] word;

    assign word = sel_right_i ? right_w_i : left_w_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sdata_o <= 1'b0;
        end else if (fall_i) begin
            if (!active_i) begin
                sh_q    <= '0;
                sdata_o <= 1'b0;
            end else if (start_i) begin
                sdata_o <= word[WORD_W-1];
                sh_q    <= {word[WORD_W-2:0], 1'b0};
            end else begin
                sdata_o <= sh_q[WORD_W-1];
                sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int HALT_SLOTS  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_i,
    input  logic              frame_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic              sdata_o
);

    localparam int CNT_W = $clog2(HALT_SLOTS + 1);
    localparam logic [CNT_W-1:0] STALL_AT = CNT_W'(HALT_SLOTS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(HALT_SLOTS);

    // ---------------- input sampling ----------------
    logic [1:0] sync_q;
    logic       bck_s;
    logic       lrck_s;

    aud_ser_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bck_i, frame_i}),
        .q_o   (sync_q)
    );

    assign bck_s  = sync_q[1];
    assign lrck_s = sync_q[0];

    // ---------------- edge and slot tracking ----------------
    logic             bck_prev;
    logic             lr_prev;
    logic [CNT_W-1:0] slot_cnt;
    logic             bck_rise;
    logic             bck_fall;
    logic             lr_rise_ev;
    logic             lr_fall_ev;
    logic             stall;

    assign bck_rise   = bck_s & ~bck_prev;
    assign bck_fall   = ~bck_s & bck_prev;
    assign lr_rise_ev = bck_rise & lrck_s & ~lr_prev;
    assign lr_fall_ev = bck_rise & ~lrck_s & lr_prev;
    assign stall      = bck_rise & (lrck_s == lr_prev) & (slot_cnt >= STALL_AT);

    // lr_prev resets high so a frame clock already high at reset is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_prev <= 1'b0;
            lr_prev  <= 1'b1;
            slot_cnt <= '0;
        end else begin
            bck_prev <= bck_s;
            if (bck_rise) begin
                lr_prev <= lrck_s;
                if (lrck_s != lr_prev) begin
                    slot_cnt <= '0;
                end else if (slot_cnt != CNT_MAX) begin
                    slot_cnt <= slot_cnt + 1'b1;
                end
            end
        end
    end

    // ---------------- controller ----------------
    state_e state_q;
    state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC: begin
                if (lr_rise_ev) state_d = ST_LEFT;
            end
            ST_LEFT: begin
                if (lr_fall_ev)  state_d = ST_RIGHT;
                else if (stall)  state_d = ST_HALT;
            end
            ST_RIGHT: begin
                if (lr_rise_ev)  state_d = ST_LEFT;
                else if (stall)  state_d = ST_HALT;
            end
            ST_HALT: begin
                if (lr_rise_ev) state_d = ST_LEFT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- outputs of the controller ----------------
    logic left_start;
    logic half_start;
    logic start_pend;
    logic active;
    logic sel_right;

    assign left_start = (state_d == ST_LEFT) && (state_q != ST_LEFT);
    assign half_start = left_start || ((state_d == ST_RIGHT) && (state_q != ST_RIGHT));
    assign active     = (state_q == ST_LEFT) || (state_q == ST_RIGHT);
    assign sel_right  = (state_q == ST_RIGHT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pend <= 1'b0;
        end else if (half_start) begin
            start_pend <= 1'b1;
        end else if (bck_fall) begin
            start_pend <= 1'b0;
        end
    end

    // ---------------- datapath ----------------
    logic [WORD_W-1:0] frame_l;
    logic [WORD_W-1:0] frame_r;

    aud_ser_pair_hold #(
        .WORD_W (WORD_W)
    ) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .left_i    (left_i),
        .right_i   (right_i),
        .xfer_i    (left_start),
        .frame_l_o (frame_l),
        .frame_r_o (frame_r)
    );

    aud_ser_shifter #(
        .WORD_W (WORD_W)
    ) shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (bck_fall),
        .active_i    (active),
        .start_i     (start_pend),
        .sel_right_i (sel_right),
        .left_w_i    (frame_l),
        .right_w_i   (frame_r),
        .sdata_o     (sdata_o)
    );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk
    import aud_ser_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            state_q,
    input logic              bck_rise,
    input logic              bck_fall,
    input logic              lrck_s,
    input logic              left_start,
    input logic [WORD_W-1:0] frame_l,
    input logic [WORD_W-1:0] frame_r,
    input logic              sdata_o
);

    // R1 / R8: once idle across a falling bit clock edge, the line is low
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SYNC || state_q == ST_HALT) &&
         ($past(state_q) == ST_SYNC || $past(state_q) == ST_HALT) &&
         $past(bck_fall)) |-> !sdata_o);

    // R3: the data line moves only after a falling bit clock edge
    p_fall_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_o != $past(sdata_o)) |-> $past(bck_fall));

    // R2: a left half is entered only at a bit clock rise with the frame clock high
    p_left_on_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEFT && $past(state_q) != ST_LEFT) |->
        ($past(bck_rise) && $past(lrck_s)));

    // R2: a right half follows only a left half, with the frame clock low
    p_right_after_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RIGHT && $past(state_q) != ST_RIGHT) |->
        ($past(state_q) == ST_LEFT && !$past(lrck_s)));

    // R6: the transmitted pair changes only at a left-half start
    p_pair_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(left_start) |-> ($stable(frame_l) && $stable(frame_r)));

    // R8: from halt only a left half may follow
    p_halt_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_HALT) |-> (state_q == ST_HALT || state_q == ST_LEFT));

endmodule

bind aud_ser_tx aud_ser_tx_chk #(
    .WORD_W (WORD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .bck_rise   (bck_rise),
    .bck_fall   (bck_fall),
    .lrck_s     (lrck_s),
    .left_start (left_start),
    .frame_l    (frame_l),
    .frame_r    (frame_r),
    .sdata_o    (sdata_o)
);

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bck;
    logic        lrck;
    logic        load;
    logic [23:0] l_in;
    logic [23:0] r_in;
    logic        sdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    aud_ser_tx dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bck_i   (bck),
        .frame_i (lrck),
        .load_i  (load),
        .left_i  (l_in),
        .right_i (r_in),
        .sdata_o (sdata)
    );

    // {mode32, left, right}
    localparam bit [48:0] VEC [6] = '{
        {1'b1, 24'hA50F3C, 24'h5AF0C3},
        {1'b1, 24'h800001, 24'h7FFFFE},
        {1'b0, 24'hC3A596, 24'h3C5A69},
        {1'b0, 24'hFFFFFF, 24'h000001},
        {1'b1, 24'h123456, 24'h654321},
        {1'b0, 24'h000000, 24'hFFFFFF}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One slot: bit clock low for 4 clk, sample just before the rising edge, high for 4 clk.
    task automatic slot(input logic lr, input bit ld, input logic [23:0] nl, input logic [23:0] nr,
                        output logic b);
        bck  = 1'b0;
        lrck = lr;
        if (ld) begin
            l_in = nl;
            r_in = nr;
            load = 1'b1;
        end
        @(negedge clk);
        load = 1'b0;
        repeat (3) @(negedge clk);
        b   = sdata;
        bck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(input int n, input bit ld, input int ld_slot, input logic [23:0] nl,
                         input logic [23:0] nr, output logic [63:0] cap);
        logic b;
        cap = '0;
        for (int s = 0; s < 2 * n; s++) begin
            slot(s < n, ld && (s == ld_slot), nl, nr, b);
            cap[63 - s] = b;
        end
    endtask

    task automatic hold_lr(input logic lr, input int cnt, output logic any_one);
        logic b;
        any_one = 1'b0;
        for (int s = 0; s < cnt; s++) begin
            slot(lr, 1'b0, '0, '0, b);
            any_one = any_one | b;
        end
    endtask

    task automatic pulse_load(input logic [23:0] nl, input logic [23:0] nr);
        @(negedge clk);
        l_in = nl;
        r_in = nr;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Expected slot stream, slot s at bit 63-s (R2, R4, R5)
    function automatic logic [63:0] exp_bits(input int n, input logic [23:0] l, input logic [23:0] r,
                                             input logic tail);
        logic [63:0] v;
        int h;
        int k;
        v = '0;
        for (int s = 0; s < 2 * n; s++) begin
            h = s / n;
            k = s % n;
            if (k == 0)
                v[63 - s] = (h == 0) ? tail : ((n == 24) ? l[0] : 1'b0);
            else if (k <= 24)
                v[63 - s] = (h == 0) ? l[24 - k] : r[24 - k];
        end
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] cap;
        logic [63:0] ex;
        logic        tail;
        logic        any;
        int          n;
        string       tag;

        rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; load = 1'b0; l_in = '0; r_in = '0;
        repeat (5) @(negedge clk);
        chk(sdata == 1'b0, "R1 reset state", {63'd0, sdata}, 64'd0);
        rst_n = 1'b1;

        // R1: pair loaded, frame clock low: nothing leaves
        pulse_load(VEC[0][47:24], VEC[0][23:0]);
        hold_lr(1'b0, 8, any);
        chk(!any, "R1 idle before first left half", {63'd0, any}, 64'd0);

        // Table walk: each frame loads the next pair late in its right half
        tail = 1'b0;
        for (int i = 0; i < 6; i++) begin
            n = VEC[i][48] ? 32 : 24;
            frame(n, i < 5, 2 * n - 4, (i < 5) ? VEC[(i + 1) % 6][47:24] : 24'h0,
                  (i < 5) ? VEC[(i + 1) % 6][23:0] : 24'h0, cap);
            ex = exp_bits(n, VEC[i][47:24], VEC[i][23:0], tail);
            tag = (n == 32) ? "R2 R4 R9 table frame" : "R2 R5 R9 table frame";
            chk(cap == ex, tag, cap, ex);
            tail = (n == 24) ? VEC[i][0] : 1'b0;
        end

        // R7: no load, the last pair repeats
        frame(32, 1'b0, 0, '0, '0, cap);
        ex = exp_bits(32, VEC[5][47:24], VEC[5][23:0], tail);
        chk(cap == ex, "R7 repeat pair", cap, ex);

        // R6: load early in the left half; this frame keeps the old pair
        frame(32, 1'b1, 3, 24'h0F0F0F, 24'hF0F0F0, cap);
        ex = exp_bits(32, VEC[5][47:24], VEC[5][23:0], 1'b0);
        chk(cap == ex, "R6 mid-frame load not mixed", cap, ex);
        frame(32, 1'b0, 0, '0, '0, cap);
        ex = exp_bits(32, 24'h0F0F0F, 24'hF0F0F0, 1'b0);
        chk(cap == ex, "R6 new pair next frame", cap, ex);

        // R8: frame clock held high past the limit, then a lone low half
        hold_lr(1'b1, 50, any);
        hold_lr(1'b0, 32, any);
        chk(!any, "R8 halted, falling frame edge ignored", {63'd0, any}, 64'd0);
        frame(32, 1'b0, 0, '0, '0, cap);
        ex = exp_bits(32, 24'h0F0F0F, 24'hF0F0F0, 1'b0);
        chk(cap == ex, "R8 resume at left half", cap, ex);

        // R1: reset in the middle of a left half, frame clock left high
        hold_lr(1'b1, 6, any);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sdata == 1'b0, "R1 mid-operation reset", {63'd0, sdata}, 64'd0);
        rst_n = 1'b1;
        pulse_load(24'hABCDEF, 24'h123123);
        hold_lr(1'b1, 32, any);
        chk(!any, "R1 high frame clock at reset release", {63'd0, any}, 64'd0);
        hold_lr(1'b0, 32, any);
        chk(!any, "R1 low half before first left", {63'd0, any}, 64'd0);
        frame(32, 1'b0, 0, '0, '0, cap);
        ex = exp_bits(32, 24'hABCDEF, 24'h123123, 1'b0);
        chk(cap == ex, "R1 R6 first frame after reset", cap, ex);

        // R3: a falling bit clock moves the line only after it, never ahead of the rise
        frame(24, 1'b0, 0, '0, '0, cap);
        ex = exp_bits(24, 24'hABCDEF, 24'h123123, 1'b0);
        chk(cap == ex, "R3 R5 R9 switch to 24 slots", cap, ex);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule